// File: doc/BRIEF.md
# MDIO Management Frame Monitor

This block listens passively to a two-wire station-management bus: a management clock and a bidirectional data line. It never drives the data line. Both wires are brought into the system clock domain. Each rising edge of the management clock yields exactly one data bit. A single state machine follows the bit stream through the preamble, start, opcode, two 5-bit address fields, turnaround and 16-bit data. It decodes both the classic (Clause 22) and the extended (Clause 45) frame formats.

When a data access completes, the monitor presents one result record for one system clock cycle. The record holds:

- the frame format;
- a read/write indication;
- both addresses and the data;
- error flags for short preamble, bad opcode and bad turnaround.

For the extended format the monitor also keeps the register address context. An address frame loads it. A read-with-increment frame advances it. Every extended-format record reports that context, with a flag that tells whether it is known. A separate one-cycle event output marks the end of an illegal bus condition.

Top module: `mdio_frame_monitor`

## Requirements
- R1: The data line is sampled once on every rising edge of the management clock, and each sample is one frame bit. The system clock runs at least 4 times faster than the management clock.
- R2: A 0 that ends a run of 1 to 31 ones sets `rec_short_pre` in the record of that frame. A run of 32 or more ones sets no flag. In both cases that 0 is taken as the first start bit.
- R3: A 0 seen when no ones have been counted (after reset or after a frame) enters an illegal-bus condition. The condition holds while the line stays 0. On the first 1 afterwards, `illegal_evt` pulses once and that 1 counts as the first preamble one.
- R4: A 0 in the second start bit marks an extended frame (`rec_c45`=1). A 1 in that bit marks a classic frame (`rec_c45`=0).
- R5: The opcode is two bits, first bit most significant. The extended format uses 00 address, 01 write, 10 read with post-increment and 11 read. The classic format uses 10 read and 01 write, and 00 or 11 sets `rec_op_err`. `rec_read` is 1 exactly when the opcode's first bit is 1.
- R6: After the opcode come the port address (5 bits), the device/register address (5 bits), two turnaround bits and the data (16 bits), each sent most significant bit first.
- R7: For opcodes 00 and 01, a first turnaround bit of 0 sets `rec_ta_err[0]`. For every opcode, a second turnaround bit of 1 sets `rec_ta_err[1]`. `rec_err` is the OR of `rec_op_err` and both turnaround flags.
- R8: An extended address frame (opcode 00) loads its data into the stored address and marks it known. It produces no record.
- R9: After an extended opcode 10 frame whose stored address is known, the stored address increases by one. The record shows the value from before the increase.
- R10: Each completed data access raises `rec_valid` for exactly one system cycle. Extended records carry the stored address in `rec_addr`, with `rec_addr_known` showing whether it is valid.
- R11: After the last data bit the monitor returns to preamble counting from zero. The ones counter saturates at 32, so idle runs of any length are accepted.
- R12: A synchronous reset clears all state: no record, no event, and the stored address unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mdc_in | input | 1 | Management clock, asynchronous |
| mdio_in | input | 1 | Management data line, asynchronous |
| rec_valid | output | 1 | One-cycle strobe: record fields are valid |
| rec_c45 | output | 1 | Extended-format frame |
| rec_read | output | 1 | Frame is a read |
| rec_port | output | 5 | Port / PHY address |
| rec_dev | output | 5 | Device / register address |
| rec_data | output | 16 | Data field |
| rec_addr | output | 16 | Stored extended register address |
| rec_addr_known | output | 1 | Stored address has been loaded |
| rec_short_pre | output | 1 | Preamble shorter than 32 ones |
| rec_op_err | output | 1 | Opcode invalid for the classic format |
| rec_ta_err | output | 2 | Turnaround fault: [0] first bit, [1] second bit |
| rec_err | output | 1 | Any opcode or turnaround fault |
| illegal_evt | output | 1 | One-cycle pulse when an illegal bus condition ends |

## Verification
The bench builds the monitor with its defaults: a 32-one preamble threshold and two synchronizer stages. It drives the management clock at one eighth of the system clock, which keeps every bit inside the required 4:1 ratio. With a 32-one threshold, a 100-one idle run drives the ones counter into saturation. Preambles of 1, 5 and 10 ones exercise the short flag.

Two more cases rely on that same threshold. A frame sent straight after a long one shows whether the counter was cleared. A chain of extended address, read-increment and read frames steps the stored address across a byte boundary. A reset part way through the run shows the stored address return to unknown.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;

  localparam int PORT_W = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;
  localparam int OP_W   = 2;
  localparam int TA_W   = 2;

  typedef enum logic [2:0] {
    PH_PRE, PH_ST, PH_OP, PH_PRT, PH_DEV, PH_TA, PH_DATA
  } phase_e;

  typedef struct packed {
    logic              c45;
    logic [OP_W-1:0]   op;
    logic              short_pre;
    logic [TA_W-1:0]   ta_bits;   // [1] first bit received, [0] second
    logic [PORT_W-1:0] port;
    logic [REG_W-1:0]  dev;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Number of bits in each counted field.
  function automatic int phase_len(phase_e ph);
    case (ph)
      PH_OP:   return OP_W;
      PH_PRT:  return PORT_W;
      PH_DEV:  return REG_W;
      PH_TA:   return TA_W;
      PH_DATA: return DATA_W;
      default: return 1;
    endcase
  endfunction

  function automatic phase_e phase_after(phase_e ph);
    case (ph)
      PH_OP:   return PH_PRT;
      PH_PRT:  return PH_DEV;
      PH_DEV:  return PH_TA;
      PH_TA:   return PH_DATA;
      default: return PH_PRE;
    endcase
  endfunction

  function automatic logic op_is_read(logic [OP_W-1:0] op);
    return op[1];
  endfunction

  // Opcodes whose first turnaround bit is driven high by the master.
  function automatic logic op_is_write_type(logic [OP_W-1:0] op);
    return !op[1];
  endfunction

  function automatic logic op_bad(logic c45, logic [OP_W-1:0] op);
    return !c45 && (op[1] == op[0]);
  endfunction

  function automatic logic [1:0] ta_fault(logic [OP_W-1:0] op,
                                          logic [TA_W-1:0] ta);
    return {ta[0], op_is_write_type(op) && !ta[1]};
  endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_addr_ctx.sv
module mdio_addr_ctx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         inc,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] addr,
  output logic         known
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      known <= 1'b0;
    end else if (load) begin
      addr  <= load_val;
      known <= 1'b1;
    end else if (inc && known) begin
      addr  <= addr + W'(1);
    end
  end

  a_r8_load_sets_known: assert property (@(posedge clk) disable iff (rst)
    load |=> known && addr == $past(load_val));

  a_r9_post_increment: assert property (@(posedge clk) disable iff (rst)
    (inc && known && !load) |=> addr == $past(addr) + W'(1));

  a_r9_unknown_stays: assert property (@(posedge clk) disable iff (rst)
    (!known && !load) |=> !known);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_mon_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   step,
  input  logic   bit_in,
  output logic   frame_done,
  output frame_t frame,
  output logic   illegal_exit
);
  localparam int CNT_W = $clog2(PRE_LEN + 1);
  localparam int IDX_W = $clog2(DATA_W);

  phase_e            phase;
  logic [CNT_W-1:0]  pre_cnt;
  logic              in_illegal;
  logic [IDX_W-1:0]  bit_idx;
  logic              c45_q, short_q;
  logic [OP_W-1:0]   op_q;
  logic [TA_W-1:0]   ta_q;
  logic [PORT_W-1:0] port_q;
  logic [REG_W-1:0]  dev_q;
  logic [DATA_W-1:0] data_q;
  logic              last_bit;
  logic              pre_zero;

  assign last_bit     = (bit_idx == IDX_W'(phase_len(phase) - 1));
  assign frame_done   = step && phase == PH_DATA && last_bit;
  assign illegal_exit = step && phase == PH_PRE && in_illegal && bit_in;
  assign pre_zero     = step && phase == PH_PRE && !in_illegal && !bit_in;

  always_comb begin
    frame.c45       = c45_q;
    frame.op        = op_q;
    frame.short_pre = short_q;
    frame.ta_bits   = ta_q;
    frame.port      = port_q;
    frame.dev       = dev_q;
    frame.data      = {data_q[DATA_W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_PRE;
      pre_cnt    <= '0;
      in_illegal <= 1'b0;
      bit_idx    <= '0;
      c45_q      <= 1'b0;
      short_q    <= 1'b0;
      op_q       <= '0;
      ta_q       <= '0;
      port_q     <= '0;
      dev_q      <= '0;
      data_q     <= '0;
    end else if (step) begin
      case (phase)
        PH_PRE: begin
          if (bit_in) begin
            in_illegal <= 1'b0;
            if (pre_cnt != CNT_W'(PRE_LEN)) pre_cnt <= pre_cnt + CNT_W'(1);
          end else if (!in_illegal) begin
            if (pre_cnt == '0) begin
              in_illegal <= 1'b1;
            end else begin
              short_q <= (pre_cnt < CNT_W'(PRE_LEN));
              phase   <= PH_ST;
            end
          end
        end
        PH_ST: begin
          c45_q   <= !bit_in;
          bit_idx <= '0;
          phase   <= PH_OP;
        end
        default: begin
          case (phase)
            PH_OP:   op_q   <= {op_q[OP_W-2:0], bit_in};
            PH_PRT:  port_q <= {port_q[PORT_W-2:0], bit_in};
            PH_DEV:  dev_q  <= {dev_q[REG_W-2:0], bit_in};
            PH_TA:   ta_q   <= {ta_q[TA_W-2:0], bit_in};
            default: data_q <= {data_q[DATA_W-2:0], bit_in};
          endcase
          if (last_bit) begin
            bit_idx <= '0;
            phase   <= phase_after(phase);
            if (phase == PH_DATA) pre_cnt <= '0;
          end else begin
            bit_idx <= bit_idx + IDX_W'(1);
          end
        end
      endcase
    end
  end

  a_r11_count_bounded: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= CNT_W'(PRE_LEN));

  a_r11_restart_preamble: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> phase == PH_PRE && pre_cnt == '0);

  a_r3_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    (step && phase == PH_PRE && in_illegal && !bit_in) |=> in_illegal);

  a_r2_short_zero_starts: assert property (@(posedge clk) disable iff (rst)
    (pre_zero && pre_cnt != '0 && pre_cnt < CNT_W'(PRE_LEN))
      |=> short_q && phase == PH_ST);

  a_r2_full_zero_starts: assert property (@(posedge clk) disable iff (rst)
    (pre_zero && pre_cnt == CNT_W'(PRE_LEN)) |=> !short_q && phase == PH_ST);
endmodule

// File: rtl/mdio_frame_monitor.sv
module mdio_frame_monitor
  import mdio_mon_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mdc_in,
  input  logic        mdio_in,
  output logic        rec_valid,
  output logic        rec_c45,
  output logic        rec_read,
  output logic [4:0]  rec_port,
  output logic [4:0]  rec_dev,
  output logic [15:0] rec_data,
  output logic [15:0] rec_addr,
  output logic        rec_addr_known,
  output logic        rec_short_pre,
  output logic        rec_op_err,
  output logic [1:0]  rec_ta_err,
  output logic        rec_err,
  output logic        illegal_evt
);
  logic [1:0] raw_pins, sync_pins;
  logic       mdc_q, step;
  logic       frame_done, illegal_exit;
  frame_t     frame;
  logic       ctx_load, ctx_inc, ctx_known;
  logic [DATA_W-1:0] ctx_addr;
  logic [1:0] ta_f;
  logic       op_f;

  assign raw_pins = {mdc_in, mdio_in};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(raw_pins[i]), .q(sync_pins[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) mdc_q <= 1'b0;
    else     mdc_q <= sync_pins[1];
  end

  assign step = sync_pins[1] && !mdc_q;

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
    .clk(clk), .rst(rst), .step(step), .bit_in(sync_pins[0]),
    .frame_done(frame_done), .frame(frame), .illegal_exit(illegal_exit)
  );

  assign ctx_load = frame_done && frame.c45 && frame.op == 2'b00;
  assign ctx_inc  = frame_done && frame.c45 && frame.op == 2'b10;

  mdio_addr_ctx #(.W(DATA_W)) u_ctx (
    .clk(clk), .rst(rst), .load(ctx_load), .inc(ctx_inc),
    .load_val(frame.data), .addr(ctx_addr), .known(ctx_known)
  );

  assign ta_f = ta_fault(frame.op, frame.ta_bits);
  assign op_f = op_bad(frame.c45, frame.op);

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid      <= 1'b0;
      illegal_evt    <= 1'b0;
      rec_c45        <= 1'b0;
      rec_read       <= 1'b0;
      rec_port       <= '0;
      rec_dev        <= '0;
      rec_data       <= '0;
      rec_addr       <= '0;
      rec_addr_known <= 1'b0;
      rec_short_pre  <= 1'b0;
      rec_op_err     <= 1'b0;
      rec_ta_err     <= '0;
      rec_err        <= 1'b0;
    end else begin
      rec_valid   <= frame_done && !ctx_load;
      illegal_evt <= illegal_exit;
      if (frame_done && !ctx_load) begin
        rec_c45        <= frame.c45;
        rec_read       <= op_is_read(frame.op);
        rec_port       <= frame.port;
        rec_dev        <= frame.dev;
        rec_data       <= frame.data;
        rec_addr       <= frame.c45 ? ctx_addr : '0;
        rec_addr_known <= frame.c45 && ctx_known;
        rec_short_pre  <= frame.short_pre;
        rec_op_err     <= op_f;
        rec_ta_err     <= ta_f;
        rec_err        <= op_f || (|ta_f);
      end
    end
  end

  a_r1_step_isolated: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  a_r8_address_silent: assert property (@(posedge clk) disable iff (rst)
    ctx_load |=> !rec_valid);

  a_r3_event_single: assert property (@(posedge clk) disable iff (rst)
    illegal_evt |=> !illegal_evt);
endmodule

// File: tb/mdio_frame_monitor_test.sv
module mdio_frame_monitor_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b0;
  logic        mdio = 1'b1;
  logic        rec_valid, rec_c45, rec_read, rec_addr_known;
  logic        rec_short_pre, rec_op_err, rec_err, illegal_evt;
  logic [4:0]  rec_port, rec_dev;
  logic [15:0] rec_data, rec_addr;
  logic [1:0]  rec_ta_err;

  always #10 clk = ~clk;

  mdio_frame_monitor uut (
    .clk(clk), .rst(rst), .mdc_in(mdc), .mdio_in(mdio),
    .rec_valid(rec_valid), .rec_c45(rec_c45), .rec_read(rec_read),
    .rec_port(rec_port), .rec_dev(rec_dev), .rec_data(rec_data),
    .rec_addr(rec_addr), .rec_addr_known(rec_addr_known),
    .rec_short_pre(rec_short_pre), .rec_op_err(rec_op_err),
    .rec_ta_err(rec_ta_err), .rec_err(rec_err), .illegal_evt(illegal_evt)
  );

  typedef struct {
    bit          c45;
    bit          rd;
    int          port;
    int          dev;
    int          data;
    int          addr;   // -1: unknown
    bit          shrt;
    bit          operr;
    int          taerr;
  } exp_t;

  exp_t exp_q[$];
  int   applied = 0;
  int   fails = 0;
  int   ctx = -1;
  int   ill_exp = 0;
  int   ill_seen = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Reference comparison on every clock, sampled at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (illegal_evt) ill_seen++;
      if (rec_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 R10 unexpected record", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rec_c45 == e.c45, "R4 format", int'(rec_c45), int'(e.c45));
          chk(rec_read == e.rd, "R5 read flag", int'(rec_read), int'(e.rd));
          chk(rec_op_err == e.operr, "R5 opcode error", int'(rec_op_err), int'(e.operr));
          chk(int'(rec_port) == e.port, "R6 port", int'(rec_port), e.port);
          chk(int'(rec_dev) == e.dev, "R6 device", int'(rec_dev), e.dev);
          chk(int'(rec_data) == e.data, "R1 R6 data", int'(rec_data), e.data);
          chk(rec_short_pre == e.shrt, "R2 R11 short preamble", int'(rec_short_pre), int'(e.shrt));
          chk(int'(rec_ta_err) == e.taerr, "R7 turnaround", int'(rec_ta_err), e.taerr);
          chk(rec_err == (e.operr || e.taerr != 0), "R7 error summary",
              int'(rec_err), int'(e.operr || e.taerr != 0));
          chk(rec_addr_known == (e.addr >= 0), "R10 R12 address known",
              int'(rec_addr_known), int'(e.addr >= 0));
          if (e.addr >= 0)
            chk(int'(rec_addr) == e.addr, "R8 R9 stored address", int'(rec_addr), e.addr);
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    mdio = b;
    mdc  = 1'b0;
    repeat (4) @(negedge clk);
    mdc  = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int pre, input bit c45, input logic [1:0] op,
                            input logic [4:0] port, input logic [4:0] dev,
                            input logic [1:0] ta, input logic [15:0] data);
    exp_t e;
    bit   wtype;
    e.c45   = c45;
    e.rd    = (op == 2'b10) || (op == 2'b11);
    e.port  = int'(port);
    e.dev   = int'(dev);
    e.data  = int'(data);
    e.addr  = c45 ? ctx : -1;
    e.shrt  = (pre < 32);
    e.operr = !c45 && (op == 2'b00 || op == 2'b11);
    wtype   = (op == 2'b00) || (op == 2'b01);
    e.taerr = ((ta[0] == 1'b1) ? 2 : 0) + ((wtype && ta[1] == 1'b0) ? 1 : 0);
    if (c45 && op == 2'b00) ctx = int'(data);
    else begin
      exp_q.push_back(e);
      if (c45 && op == 2'b10 && ctx >= 0) ctx = (ctx + 1) % 65536;
    end
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(c45 ? 1'b0 : 1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(port[i]);
    for (int i = 4; i >= 0; i--) send_bit(dev[i]);
    send_bit(ta[1]);
    send_bit(ta[0]);
    for (int i = 15; i >= 0; i--) send_bit(data[i]);
    mdc = 1'b0;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R8 R10 record count", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    mdc = 1'b0;
    mdio = 1'b1;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(rec_valid == 1'b0, "R12 reset strobe", int'(rec_valid), 0);
    chk(illegal_evt == 1'b0, "R12 reset event", int'(illegal_evt), 0);
    chk(rec_addr_known == 1'b0, "R12 reset address flag", int'(rec_addr_known), 0);
    rst = 1'b0;
    ctx = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog R1", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    repeat (3) @(negedge clk);

    // R4 R5: classic read, full preamble
    send_frame(40, 0, 2'b10, 5'd3, 5'd5, 2'b10, 16'hA5C3);
    // R11: counter must be cleared -> short after a long frame (R2)
    send_frame(5, 0, 2'b01, 5'd31, 5'd0, 2'b10, 16'h1234);
    // R5 R7: invalid opcodes with turnaround faults
    send_frame(10, 0, 2'b11, 5'd1, 5'd2, 2'b01, 16'hFFFF);
    send_frame(32, 0, 2'b00, 5'd16, 5'd17, 2'b00, 16'h0001);
    send_frame(32, 0, 2'b01, 5'd9, 5'd9, 2'b11, 16'h8000);
    // R10: extended read before any address frame -> unknown
    send_frame(33, 1, 2'b11, 5'd4, 5'd1, 2'b00, 16'h5A5A);
    // R8: address frame, then R9 increments across a byte boundary
    send_frame(32, 1, 2'b00, 5'd4, 5'd1, 2'b10, 16'h00FE);
    send_frame(32, 1, 2'b10, 5'd4, 5'd1, 2'b00, 16'h1111);
    send_frame(1, 1, 2'b10, 5'd4, 5'd1, 2'b00, 16'h2222);
    send_frame(32, 1, 2'b11, 5'd4, 5'd1, 2'b00, 16'h3333);
    send_frame(32, 1, 2'b01, 5'd4, 5'd1, 2'b01, 16'h4444);

    // R3: zeros with no preamble -> illegal, exit pulse on first one
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    chk(ill_seen == ill_exp, "R3 no event while low", ill_seen, ill_exp);
    ill_exp++;
    send_frame(33, 0, 2'b10, 5'd7, 5'd8, 2'b00, 16'hBEEF);
    chk(ill_seen == ill_exp, "R3 illegal exit event", ill_seen, ill_exp);

    // R11: long idle saturates the counter
    send_frame(100, 0, 2'b01, 5'd2, 5'd3, 2'b10, 16'hC0DE);

    // R12: reset clears the stored address
    do_reset();
    for (int i = 0; i < 2; i++) send_bit(1'b0);
    ill_exp++;
    send_frame(32, 1, 2'b11, 5'd0, 5'd30, 2'b00, 16'h0F0F);
    chk(ill_seen == ill_exp, "R3 illegal after reset", ill_seen, ill_exp);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule